// File: doc/BRIEF.md
# Decimal Key Priority Encoder

This block turns a set of nine decimal key lines, digits one to nine, into a four-bit BCD code. Every key line is active LOW: a line held at 0 means the key is down. When several keys are down together, the highest digit is reported and the lower ones have no effect. No line exists for digit zero. With no digit key down, the code is zero.

The encoded value is presented in two forms. The first, `code_n`, is complemented (active LOW), so it reads 4'b1111 when no digit key is down. The second, `bcd`, is in true polarity. A tenth line carries the zero key of a keypad. It never changes the code. It only feeds `key_hit`, a flag that tells the surrounding logic that some key is down, including a lone zero. The block is purely combinational. Debounce and matrix scanning are done outside it.

Top module: `key_prio_encoder`

## Requirements
- R1: Key line `key_n[i]` stands for decimal digit i+1 (bit 0 is digit 1, bit 8 is digit 9). With exactly one line at 0, `code_n` equals the bitwise complement of that digit's four-bit BCD value.
- R2: With several lines at 0, the output encodes the highest digit among them, whatever the state of the lower lines.
- R3: With every digit line at 1, `code_n` is 4'b1111 and `bcd` is 4'b0000.
- R4: A line at logic 1 is a released key and never contributes to the code.
- R5: `zero_key_n` has no effect on `code_n` or `bcd`.
- R6: `key_hit` is 1 exactly when at least one of the ten lines (nine digit lines plus `zero_key_n`) is at 0.
- R7: `bcd` is always the bitwise inverse of `code_n`.
- R8: `bcd` never exceeds 9 for any input pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| key_n | input | 9 | Digit key lines 1..9, active LOW, bit i = digit i+1 |
| zero_key_n | input | 1 | Zero key line, active LOW, used only for key detection |
| code_n | output | 4 | Complemented BCD of the winning digit |
| bcd | output | 4 | True-polarity BCD of the winning digit |
| key_hit | output | 1 | High while any of the ten key lines is low |

## Verification
The block holds no state. A fault therefore shows up as a wrong code in the same evaluation as the input pattern that exposes it, and nothing can persist from one pattern to the next. The bench applies all 512 digit-line patterns, each with the zero key both up and down. This exposes a broken priority order, a swapped bit position, a leak from the zero key into the code, or a detection flag that misses a lone zero, all on the first pattern that exercises the faulty path.

// File: rtl/key_prio_encoder.sv
module key_prio_encoder #(
  parameter int KEYS = 9,
  localparam int CODE_W = $clog2(KEYS + 1)
) (
  input  logic [KEYS-1:0]   key_n,
  input  logic              zero_key_n,
  output logic [CODE_W-1:0] code_n,
  output logic [CODE_W-1:0] bcd,
  output logic              key_hit
);

  logic [CODE_W-1:0] winner;

  // later (higher) digits overwrite earlier ones
  always_comb begin
    winner = '0;
    for (int i = 0; i < KEYS; i++)
      if (!key_n[i]) winner = CODE_W'(i + 1);
  end

  assign code_n  = ~winner;
  assign bcd     = winner;
  assign key_hit = ~(&key_n) | ~zero_key_n;

endmodule

module key_prio_encoder_chk #(
  parameter int KEYS = 9,
  localparam int CODE_W = $clog2(KEYS + 1)
) (
  input logic [KEYS-1:0]   key_n,
  input logic              zero_key_n,
  input logic [CODE_W-1:0] code_n,
  input logic [CODE_W-1:0] bcd,
  input logic              key_hit
);

  always_comb begin
    if (!$isunknown({key_n, zero_key_n})) begin
      // R3
      idle_code_chk: assert (!(&key_n) || (code_n == '1 && bcd == '0));
      // R2
      top_key_chk: assert (key_n[KEYS-1] || bcd == CODE_W'(KEYS));
      // R6
      hit_flag_chk: assert (key_hit == ((~key_n) != '0 || !zero_key_n));
      // R7
      polarity_chk: assert ((bcd ^ code_n) == '1);
      // R8
      range_chk: assert (bcd <= CODE_W'(KEYS));
      // R1
      if ($countones(~key_n) == 1) begin
        for (int i = 0; i < KEYS; i++)
          if (!key_n[i]) single_key_chk: assert (bcd == CODE_W'(i + 1));
      end
    end
  end

endmodule

bind key_prio_encoder key_prio_encoder_chk #(.KEYS(KEYS)) u_chk (
  .key_n(key_n), .zero_key_n(zero_key_n), .code_n(code_n),
  .bcd(bcd), .key_hit(key_hit)
);

// File: tb/sim_key_prio_encoder.sv
module sim_key_prio_encoder;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic [8:0] key_n = '1;
  logic       zero_key_n = 1'b1;
  logic [3:0] code_n, bcd;
  logic       key_hit;
  int checks = 0, fails = 0;
  bit done = 0;

  key_prio_encoder u0 (.key_n(key_n), .zero_key_n(zero_key_n),
                       .code_n(code_n), .bcd(bcd), .key_hit(key_hit));

  function automatic logic [3:0] want_digit(logic [8:0] p);
    logic [3:0] d = 4'd0;
    for (int k = 1; k <= 9; k++) if (p[k-1] == 1'b0) d = 4'(k);
    return d;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s key_n=%b zero=%b actual=%h expected=%h",
               req, key_n, zero_key_n, act, exp);
    end
  endtask

  task automatic apply(logic [8:0] p, logic z);
    @(posedge clk); key_n = p; zero_key_n = z;
    @(negedge clk);
  endtask

  task automatic t_idle;
    apply('1, 1'b1);
    chk("R3 code_n", {4'h0, code_n}, 8'h0F);
    chk("R3 bcd", {4'h0, bcd}, 8'h00);
    chk("R6 no hit", {7'h0, key_hit}, 8'h00);
  endtask

  task automatic t_single;
    for (int k = 1; k <= 9; k++) begin
      apply(~(9'd1 << (k - 1)), 1'b1);
      chk("R1 single", {4'h0, code_n}, {4'h0, ~4'(k)});
      chk("R4 others released", {4'h0, bcd}, 8'(k));
    end
  endtask

  task automatic t_priority;
    apply(9'b0_0000_0000, 1'b1);
    chk("R2 all pressed", {4'h0, bcd}, 8'd9);
    apply(9'b1_1010_0110, 1'b1);
    chk("R2 mixed", {4'h0, bcd}, 8'd7);
    apply(9'b1_1111_1100, 1'b1);
    chk("R2 low pair", {4'h0, bcd}, 8'd2);
  endtask

  task automatic t_zero_key;
    apply('1, 1'b0);
    chk("R5 zero only code", {4'h0, code_n}, 8'h0F);
    chk("R6 zero only hit", {7'h0, key_hit}, 8'h01);
    apply(9'b1_1110_1111, 1'b0);
    chk("R5 zero with 5", {4'h0, bcd}, 8'd5);
  endtask

  task automatic t_exhaustive;
    for (int z = 0; z < 2; z++)
      for (int p = 0; p < 512; p++) begin
        logic [3:0] d;
        apply(9'(p), 1'(z));
        d = want_digit(9'(p));
        chk("R2 exhaustive", {4'h0, bcd}, {4'h0, d});
        chk("R7 inverse", {4'h0, code_n}, {4'h0, ~d});
        chk("R6 hit", {7'h0, key_hit}, {7'h0, (p != 511) || (z == 0)});
        checks++;
        if (bcd > 4'd9) begin
          fails++;
          $display("FAIL R8 actual=%0d expected<=9", bcd);
        end
      end
  endtask

  initial begin
    t_idle();
    t_single();
    t_priority();
    t_zero_key();
    t_exhaustive();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule